// File: doc/BRIEF.md
# Vectored Local Interrupt Priority Controller

This block sits beside one processor and arbitrates among 256 interrupt vectors. Each vector has a priority class, which is its upper four bits. A larger vector means higher priority. Incoming requests pass an acceptance gate set by a software-written task-priority class. Requests that pass are recorded in a pending bit array. The processor's interrupt-enable level plays no part in acceptance, so requests keep piling up while the processor is masked.

Delivery is a separate gate. A processor-priority class is formed from the task-priority class and the class of the highest vector now in service. The highest pending vector is presented only if its class is strictly above that processor-priority class and the processor has interrupts enabled.

When the processor acknowledges the presented vector, the vector moves from pending to in-service on that edge. Each end-of-interrupt retires the highest in-service vector. Higher vectors therefore nest above lower ones, and lower vectors wait until everything above them has retired.

Top module: `vlic_top`

## Requirements
- R1: While `rst_n` is low and for two clock edges after it rises, no request is recorded. After reset the pending and in-service arrays are empty, the task-priority class is 0 and `irq_out` is 0.
- R2: A request is accepted into the pending array only if `req_vec[7:4]` is strictly greater than the task-priority class. A rejected request leaves no trace, even after the task priority is lowered later.
- R3: Acceptance does not depend on `cpu_ie`. A request accepted while `cpu_ie` is 0 is held, and `irq_out` stays 0 until `cpu_ie` is 1.
- R4: `irq_out` is 1 exactly when `cpu_ie` is 1 and the class of the highest pending vector is strictly above the processor-priority class. `irq_vec` then carries that vector, and it reads 0 whenever `irq_out` is 0. A request accepted on one edge is visible on the outputs right after that edge.
- R5: The processor-priority class is the larger of the task-priority class and the class of the highest in-service vector. With nothing in service, it is the task-priority class. Writing `tpr_wdata` with `tpr_we` high takes effect on the next edge.
- R6: When `irq_ack` is high while `irq_out` is 1, the presented vector's pending bit is cleared and its in-service bit is set on the same edge. When `irq_ack` is high while `irq_out` is 0, it is ignored.
- R7: A pending vector whose class is above every in-service class is delivered at once, nesting above the vector in service.
- R8: A pending vector below an in-service vector stays undelivered until end-of-interrupt has retired every in-service vector of its class or higher.
- R9: `eoi_valid` clears only the highest set in-service bit. With nothing in service it is ignored.
- R10: A request for a vector that is already pending is merged and is delivered only once.
- R11: When several vectors are pending and interrupts are enabled, they are delivered from the highest vector downward.
- R12: A pending vector in the same class as the highest in-service vector is not delivered, because the comparison is strict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Interrupt request strobe |
| req_vec | input | 8 | Vector of the request |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write enable |
| tpr_wdata | input | 4 | New task-priority class |
| cpu_ie | input | 1 | Processor interrupt-enable level |
| irq_ack | input | 1 | Processor acknowledge of the presented vector |
| irq_out | output | 1 | Interrupt line to the processor |
| irq_vec | output | 8 | Vector presented with `irq_out`, 0 when idle |

## Verification
All state (the task priority, the pending array and the in-service array) changes only on a clock edge. The outputs are combinational from that state, so the effect of a strobe sampled on one edge appears in the same clock period, just after that edge. Every change of `cpu_ie` shows on the outputs with no edge at all. The bench drives each input on a falling edge and reads `irq_out` and `irq_vec` on the next falling edge, which is the first point where that single edge's result is settled. After reset is released, the bench waits three edges so that the two-stage reset release has completed before the first stimulus.

// File: rtl/vlic_pkg.sv
`timescale 1ns/1ps
package vlic_pkg;
  localparam int VEC_W_DEF = 8;
  localparam int CLS_W_DEF = 4;

  // result of a highest-set-bit search
  typedef struct packed {
    logic                 found;
    logic [VEC_W_DEF-1:0] idx;
  } hit_t;
endpackage

// File: rtl/vlic_hi_find.sv
`timescale 1ns/1ps
// Finds the highest set bit of a vector; lower bits lose.
module vlic_hi_find #(
  parameter int W  = 256,
  parameter int IW = 8
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vlic_bitset.sv
`timescale 1ns/1ps
// One-hot set/clear bit array; a clear and a set on the same edge apply
// clear first, so a set of the same index survives.
module vlic_bitset #(
  parameter int W  = 256,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [W-1:0]  bits
);
  logic [W-1:0] bits_q, bits_d, set_mask, clr_mask;
  logic         upd;

  always_comb begin
    set_mask = set_en ? (W'(1) << set_idx) : '0;
    clr_mask = clr_en ? (W'(1) << clr_idx) : '0;
    upd      = set_en | clr_en;
    bits_d   = (bits_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bits_q <= '0;
    else if (upd) bits_q <= bits_d;
  end

  assign bits = bits_q;
endmodule

// File: rtl/vlic_ppr.sv
`timescale 1ns/1ps
// Processor-priority class: larger of task class and top in-service class.
module vlic_ppr #(
  parameter int CLS_W = 4
) (
  input  logic [CLS_W-1:0] tpr_cls,
  input  logic             isr_found,
  input  logic [CLS_W-1:0] isr_cls,
  output logic [CLS_W-1:0] ppr_cls
);
  always_comb begin
    if (isr_found && (isr_cls > tpr_cls)) ppr_cls = isr_cls;
    else                                  ppr_cls = tpr_cls;
  end
endmodule

// File: rtl/vlic_top.sv
`timescale 1ns/1ps
module vlic_top #(
  parameter int VEC_W = vlic_pkg::VEC_W_DEF,
  parameter int CLS_W = vlic_pkg::CLS_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             eoi_valid,
  input  logic             tpr_we,
  input  logic [CLS_W-1:0] tpr_wdata,
  input  logic             cpu_ie,
  input  logic             irq_ack,
  output logic             irq_out,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int NVEC = 1 << VEC_W;
  localparam int LO   = VEC_W - CLS_W;

  // reset release synchronizer
  logic [1:0] rsync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  // task priority class
  logic [CLS_W-1:0] tpr_q, tpr_d;

  always_comb tpr_d = tpr_wdata;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     tpr_q <= '0;
    else if (tpr_we) tpr_q <= tpr_d;
  end

  // arrays and their highest entries
  logic [NVEC-1:0]  pend_bits, isr_bits;
  logic             pend_found, isr_found;
  logic [VEC_W-1:0] pend_idx, isr_idx;
  logic [CLS_W-1:0] ppr_cls;
  logic             accept, take, retire, deliverable;

  always_comb begin
    accept      = req_valid && (req_vec[VEC_W-1:LO] > tpr_q);
    deliverable = pend_found && (pend_idx[VEC_W-1:LO] > ppr_cls);
    irq_out     = deliverable && cpu_ie;
    irq_vec     = irq_out ? pend_idx : '0;
    take        = irq_ack && irq_out;
    retire      = eoi_valid && isr_found;
  end

  vlic_hi_find #(.W(NVEC), .IW(VEC_W)) u_pend_top (
    .bits(pend_bits), .found(pend_found), .idx(pend_idx)
  );

  vlic_hi_find #(.W(NVEC), .IW(VEC_W)) u_isr_top (
    .bits(isr_bits), .found(isr_found), .idx(isr_idx)
  );

  vlic_ppr #(.CLS_W(CLS_W)) u_ppr (
    .tpr_cls  (tpr_q),
    .isr_found(isr_found),
    .isr_cls  (isr_idx[VEC_W-1:LO]),
    .ppr_cls  (ppr_cls)
  );

  vlic_bitset #(.W(NVEC), .IW(VEC_W)) u_pend (
    .clk(clk), .rst_n(rst_ok),
    .set_en(accept), .set_idx(req_vec),
    .clr_en(take),   .clr_idx(pend_idx),
    .bits(pend_bits)
  );

  vlic_bitset #(.W(NVEC), .IW(VEC_W)) u_isr (
    .clk(clk), .rst_n(rst_ok),
    .set_en(take),   .set_idx(pend_idx),
    .clr_en(retire), .clr_idx(isr_idx),
    .bits(isr_bits)
  );
endmodule

// File: rtl/vlic_checks.sv
`timescale 1ns/1ps
module vlic_checks #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input logic                  clk,
  input logic                  rst_ok,
  input logic                  req_valid,
  input logic [VEC_W-1:0]      req_vec,
  input logic                  eoi_valid,
  input logic                  cpu_ie,
  input logic                  irq_ack,
  input logic                  irq_out,
  input logic [VEC_W-1:0]      irq_vec,
  input logic [CLS_W-1:0]      tpr_q,
  input logic [(1<<VEC_W)-1:0] pend_q,
  input logic [(1<<VEC_W)-1:0] isr_q
);
  localparam int LO = VEC_W - CLS_W;

  logic [VEC_W-1:0] irq_base;
  assign irq_base = {irq_vec[VEC_W-1:LO], {LO{1'b0}}};

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_vec[VEC_W-1:LO] > tpr_q) |=> pend_q[$past(req_vec)]);

  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && req_vec[VEC_W-1:LO] <= tpr_q && !pend_q[req_vec])
      |=> !pend_q[$past(req_vec)]);

  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    !cpu_ie |-> !irq_out);

  p_present_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_out |-> (pend_q[irq_vec] && irq_vec[VEC_W-1:LO] > tpr_q));

  p_ack_move_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_ack && irq_out && !(req_valid && req_vec == irq_vec))
      |=> (isr_q[$past(irq_vec)] && !pend_q[$past(irq_vec)]));

  p_ack_idle_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_ack && !irq_out && !eoi_valid) |=> isr_q == $past(isr_q));

  // R8 and R12: no in-service vector in the presented class or above
  p_above_isr_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_out |-> ((isr_q >> irq_base) == '0));

  p_eoi_one_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (eoi_valid && isr_q != '0 && !(irq_ack && irq_out))
      |=> $countones(isr_q) == $countones($past(isr_q)) - 1);

  p_eoi_empty_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (eoi_valid && isr_q == '0 && !(irq_ack && irq_out)) |=> isr_q == '0);
endmodule

bind vlic_top vlic_checks #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .req_valid(req_valid), .req_vec(req_vec),
  .eoi_valid(eoi_valid), .cpu_ie(cpu_ie), .irq_ack(irq_ack),
  .irq_out(irq_out), .irq_vec(irq_vec), .tpr_q(tpr_q),
  .pend_q(pend_bits), .isr_q(isr_bits)
);

// File: tb/vlic_top_test.sv
`timescale 1ns/1ps
module vlic_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, eoi_valid, tpr_we, cpu_ie, irq_ack;
  logic [7:0] req_vec;
  logic [3:0] tpr_wdata;
  logic       irq_out;
  logic [7:0] irq_vec;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  vlic_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .eoi_valid(eoi_valid), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .cpu_ie(cpu_ie), .irq_ack(irq_ack), .irq_out(irq_out), .irq_vec(irq_vec)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_irq(input string tag, input logic on, input logic [7:0] v);
    logic [8:0] act, exp;
    act = {irq_out, irq_vec};
    exp = {on, on ? v : 8'h00};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual irq=%b vec=%02h expected irq=%b vec=%02h",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  task automatic req(input logic [7:0] v);
    req_valid = 1'b1; req_vec = v; tick(); req_valid = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic eoi();
    eoi_valid = 1'b1; tick(); eoi_valid = 1'b0;
  endtask

  task automatic set_tpr(input logic [3:0] c);
    tpr_we = 1'b1; tpr_wdata = c; tick(); tpr_we = 1'b0;
  endtask

  task automatic reset_dut();
    rst_n = 1'b0; req_valid = 1'b0; req_vec = '0; eoi_valid = 1'b0;
    tpr_we = 1'b0; tpr_wdata = '0; cpu_ie = 1'b1; irq_ack = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic t_reset_r1();
    rst_n = 1'b0; cpu_ie = 1'b1; req_valid = 1'b1; req_vec = 8'hF0;
    tick();
    expect_irq("R1 in reset", 1'b0, 8'h00);
    rst_n = 1'b1;
    tick();
    req_valid = 1'b0;
    tick(); tick();
    expect_irq("R1 request during reset release dropped", 1'b0, 8'h00);
    reset_dut();
    expect_irq("R1 idle after reset", 1'b0, 8'h00);
  endtask

  task automatic t_accept_r2();
    reset_dut();
    set_tpr(4'h5);
    req(8'h45);
    expect_irq("R2 class below task priority rejected", 1'b0, 8'h00);
    req(8'h55);
    expect_irq("R2 class equal to task priority rejected", 1'b0, 8'h00);
    req(8'h62);
    expect_irq("R2 R4 class above accepted and presented", 1'b1, 8'h62);
    ack(); eoi();
    set_tpr(4'h0);
    expect_irq("R2 rejected requests leave no trace", 1'b0, 8'h00);
  endtask

  task automatic t_masked_r3_r11();
    reset_dut();
    cpu_ie = 1'b0;
    req(8'h31); req(8'h90); req(8'h5A);
    expect_irq("R3 held while masked", 1'b0, 8'h00);
    cpu_ie = 1'b1;
    #1;
    expect_irq("R11 highest delivered first", 1'b1, 8'h90);
    tick();
    ack();
    expect_irq("R8 lower held under 0x90", 1'b0, 8'h00);
    eoi();
    expect_irq("R11 second 0x5A", 1'b1, 8'h5A);
    ack(); eoi();
    expect_irq("R11 third 0x31", 1'b1, 8'h31);
    ack(); eoi();
    expect_irq("R11 drained", 1'b0, 8'h00);
  endtask

  task automatic t_nest_r7_r12();
    reset_dut();
    req(8'h40); ack();
    expect_irq("R6 acked vector leaves pending", 1'b0, 8'h00);
    req(8'h80);
    expect_irq("R7 higher class nests", 1'b1, 8'h80);
    ack(); eoi();
    req(8'h42);
    expect_irq("R9 R12 same class as remaining 0x40 held", 1'b0, 8'h00);
    eoi();
    expect_irq("R9 second EOI retires 0x40", 1'b1, 8'h42);
    ack(); eoi();
  endtask

  task automatic t_hold_r8();
    reset_dut();
    req(8'h70); ack();
    req(8'h30); req(8'h60);
    expect_irq("R8 lower vectors held", 1'b0, 8'h00);
    eoi();
    expect_irq("R8 released after EOI, highest first", 1'b1, 8'h60);
    ack(); eoi();
    expect_irq("R8 next lower", 1'b1, 8'h30);
  endtask

  task automatic t_ppr_r5();
    reset_dut();
    req(8'h30); ack();
    req(8'h41);
    expect_irq("R5 class 4 above in-service class 3", 1'b1, 8'h41);
    set_tpr(4'h5);
    expect_irq("R5 task priority dominates", 1'b0, 8'h00);
    set_tpr(4'h2);
    expect_irq("R5 in-service class dominates", 1'b1, 8'h41);
  endtask

  task automatic t_ack_idle_r6();
    reset_dut();
    cpu_ie = 1'b0;
    req(8'h90);
    ack();
    cpu_ie = 1'b1;
    #1;
    expect_irq("R6 ack while idle ignored", 1'b1, 8'h90);
    tick();
  endtask

  task automatic t_dup_r10();
    reset_dut();
    cpu_ie = 1'b0;
    req(8'h77); req(8'h77);
    cpu_ie = 1'b1;
    tick();
    expect_irq("R10 merged request presented", 1'b1, 8'h77);
    ack();
    expect_irq("R10 no second copy pending", 1'b0, 8'h00);
    eoi();
    expect_irq("R10 still no copy after EOI", 1'b0, 8'h00);
  endtask

  task automatic t_eoi_empty_r9();
    reset_dut();
    eoi();
    req(8'h50); ack();
    req(8'h20);
    expect_irq("R9 stray EOI did not retire later vector", 1'b0, 8'h00);
    eoi();
    expect_irq("R9 real EOI releases lower", 1'b1, 8'h20);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset_r1();
    t_accept_r2();
    t_masked_r3_r11();
    t_nest_r7_r12();
    t_hold_r8();
    t_ppr_r5();
    t_ack_idle_r6();
    t_dup_r10();
    t_eoi_empty_r9();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule